// File: doc/BRIEF.md
# Three-Channel Square-Wave Tone Mixer

This block turns three pointer channels into programmable square-wave tone generators and mixes their outputs into one 4-bit audio sample. Each channel keeps an 8-bit down counter, a start count, an end count and a level flag. In tone mode the counter steps once per clock event and reloads from the start count after it passes zero, so the tone period is the start count plus one events. The flag goes high when the counter equals the start count and low when it equals the end count. The end count therefore sets the duty cycle.

Software or a host state machine programs each channel through a small write port. Each write selects a channel, a register kind and a data byte. The three flags, each gated by its channel's tone-mode bit, form an index into a fixed nonlinear level table. The table result is presented combinationally on `sample`, so a read at any moment sees the current level. The slow oscillator is outside the block and arrives as a one-cycle tick enable that is synchronous to the system clock.

Top module: `tone_music_gen`

## Requirements
- R1: While synchronous active-low reset is asserted, all state clears (counters, start/end counts, flags, mode bits). From the cycle after a reset edge, `sample` is 0.
- R2: A channel whose tone-mode bit (control bit 4) is 0 contributes 0 to the mixer index, whatever its flag holds. Outside tone mode its counter does not step.
- R3: The mixer index is {ch0, ch1, ch2} gated flags, with channel 0 as bit 2. `sample` for index 0..7 is 0x0, 0x4, 0x5, 0x9, 0x6, 0xA, 0xB, 0xF.
- R4: In tone mode with control bit 5 = 1, the counter steps only on cycles where `osc_tick` is high. A step from a value greater than 0 decrements the counter. A step from 0 reloads it from the start count.
- R5: Every cycle, the flag is set if the counter equals the start count. Otherwise it is cleared if the counter equals the end count, and otherwise it holds. The flag is visible on `sample` two clock edges after the event that moved the counter.
- R6: When start equals end and the counter reaches that value, setting wins.
- R7: A write of the start count changes neither the current counter value nor the current step. The new value is used from the next reload on.
- R8: A pointer-low write loads the counter with the start count when the channel is in tone mode, and with the written byte when it is not.
- R9: With control bit 5 = 0, a tone-mode channel steps on its own bit of `rd_pulse` and ignores `osc_tick`.
- R10: Register kinds on `wr_kind` are 0 = start count, 1 = end count, 2 = pointer low, 3 = control. Control bits 3..0 (upper pointer bits) have no effect here. A write with `wr_chan` = 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| osc_tick | input | 1 | One-cycle oscillator step enable |
| rd_pulse | input | 3 | Per-channel read strobe, used as step source when control bit 5 = 0 |
| wr_en | input | 1 | Register write strobe |
| wr_kind | input | 2 | Register kind: 0 start, 1 end, 2 pointer low, 3 control |
| wr_chan | input | 2 | Channel select, 0..2 |
| wr_data | input | 8 | Write data byte |
| sample | output | 4 | Mixed 4-bit audio level |

## Verification
The mixer is swept exhaustively. All three flags are held high and the eight tone-mode combinations are walked, which separates each channel's weight and exposes a swapped index order. A single channel is then run through every start count from 0 to 7 paired with every end count from 0 to 8, across more than two periods. This separates end counts below, equal to and above the start count, and so distinguishes the duty behaviour, the set-over-clear priority and the reload point. Directed sequences cover several cases: changing the start count mid-period, which tells next-reload from immediate load; pointer-low writes inside and outside tone mode; a read-pulse clock source that must ignore oscillator ticks; and a write to the unused channel index.

// File: rtl/tone_pkg.sv
// Package: shared constants, register-kind encoding and the level table
// for the three-channel tone mixer. Assumes exactly three channels.
package tone_pkg;

    localparam int NUM_CH   = 3;
    localparam int CNT_W    = 8;
    localparam int LEVEL_W  = 4;
    localparam int CH_IDX_W = 2;

    // Control byte bit positions
    localparam int CTRL_SRC_BIT  = 5;
    localparam int CTRL_TONE_BIT = 4;

    typedef enum logic [1:0] {
        KIND_START = 2'd0,
        KIND_END   = 2'd1,
        KIND_LOW   = 2'd2,
        KIND_CTRL  = 2'd3
    } reg_kind_e;

    // Fixed nonlinear level table; index bit 2 is channel 0
    function automatic logic [LEVEL_W-1:0] level_of(input logic [NUM_CH-1:0] idx);
        logic [LEVEL_W-1:0] lv;
        case (idx)
            3'b000:  lv = 4'h0;
            3'b001:  lv = 4'h4;
            3'b010:  lv = 4'h5;
            3'b011:  lv = 4'h9;
            3'b100:  lv = 4'h6;
            3'b101:  lv = 4'hA;
            3'b110:  lv = 4'hB;
            default: lv = 4'hF;
        endcase
        return lv;
    endfunction

endpackage

// File: rtl/tone_wr_decode.sv
// Write decoder: turns the shared write port into per-channel, per-kind
// one-cycle strobes. Assumes wr_chan values at or above NUM_CH select nothing.
module tone_wr_decode
    import tone_pkg::*;
#(
    parameter int N_CH  = NUM_CH,
    parameter int IDX_W = CH_IDX_W
) (
    input  logic             wr_en,
    input  logic [1:0]       wr_kind,
    input  logic [IDX_W-1:0] wr_chan,
    output logic [N_CH-1:0]  wr_start,
    output logic [N_CH-1:0]  wr_end,
    output logic [N_CH-1:0]  wr_low,
    output logic [N_CH-1:0]  wr_ctrl
);

    genvar gi;
    generate
        for (gi = 0; gi < N_CH; gi++) begin : g_dec
            logic hit;
            // Purpose: match this channel's index on an active write
            always_comb hit = wr_en && (wr_chan == IDX_W'(gi));
            // Purpose: split the hit by register kind
            always_comb begin
                wr_start[gi] = hit && (wr_kind == KIND_START);
                wr_end[gi]   = hit && (wr_kind == KIND_END);
                wr_low[gi]   = hit && (wr_kind == KIND_LOW);
                wr_ctrl[gi]  = hit && (wr_kind == KIND_CTRL);
            end
        end
    endgenerate

endmodule

// File: rtl/tone_channel.sv
// One tone channel: start/end registers, mode bits, 8-bit down counter with
// reload from the start count, and the duty flag. Assumes write strobes are
// one-hot per cycle and osc_tick is a single-cycle enable.
module tone_channel
    import tone_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         osc_tick,
    input  logic         rd_pulse,
    input  logic         wr_start,
    input  logic         wr_end,
    input  logic         wr_low,
    input  logic         wr_ctrl,
    input  logic [7:0]   wr_data,
    output logic [W-1:0] cnt_o,
    output logic [W-1:0] start_o,
    output logic         flag_o,
    output logic         tone_o,
    output logic         src_o
);

    logic [W-1:0] cnt_q, start_q, end_q;
    logic         flag_q, tone_q, src_q;
    logic         step;

    // Purpose: choose the step event from the selected clock source
    always_comb step = tone_q && (src_q ? osc_tick : rd_pulse);

    // Purpose: hold start and end counts
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= '0;
            end_q   <= '0;
        end else begin
            if (wr_start) start_q <= wr_data[W-1:0];
            if (wr_end)   end_q   <= wr_data[W-1:0];
        end
    end

    // Purpose: hold the tone-mode and clock-source bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tone_q <= 1'b0;
            src_q  <= 1'b0;
        end else if (wr_ctrl) begin
            tone_q <= wr_data[CTRL_TONE_BIT];
            src_q  <= wr_data[CTRL_SRC_BIT];
        end
    end

    // Purpose: pointer-low load, else decrement with reload after zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (wr_low) begin
            cnt_q <= tone_q ? start_q : wr_data[W-1:0];
        end else if (step) begin
            cnt_q <= (cnt_q == '0) ? start_q : cnt_q - 1'b1;
        end
    end

    // Purpose: set on start match (priority), clear on end match
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (cnt_q == start_q) begin
            flag_q <= 1'b1;
        end else if (cnt_q == end_q) begin
            flag_q <= 1'b0;
        end
    end

    assign cnt_o   = cnt_q;
    assign start_o = start_q;
    assign flag_o  = flag_q;
    assign tone_o  = tone_q;
    assign src_o   = src_q;

endmodule

// File: rtl/tone_mixer.sv
// Mixer: gates each flag with its tone-mode bit and maps the 3-bit index
// through the fixed level table. Purely combinational; assumes three channels.
module tone_mixer
    import tone_pkg::*;
#(
    parameter int N_CH = NUM_CH,
    parameter int LW   = LEVEL_W
) (
    input  logic [N_CH-1:0] flag,
    input  logic [N_CH-1:0] tone,
    output logic [LW-1:0]   level
);

    logic [N_CH-1:0] idx;

    genvar gi;
    generate
        for (gi = 0; gi < N_CH; gi++) begin : g_idx
            // Purpose: channel 0 lands in the top index bit
            always_comb idx[N_CH-1-gi] = flag[gi] && tone[gi];
        end
    endgenerate

    // Purpose: table lookup
    always_comb level = level_of(idx);

endmodule

// File: rtl/tone_music_gen.sv
// Top: three tone channels sharing one write port, mixed to a 4-bit level.
// Assumes osc_tick is synchronous, one cycle wide and much rarer than clk.
module tone_music_gen
    import tone_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                osc_tick,
    input  logic [NUM_CH-1:0]   rd_pulse,
    input  logic                wr_en,
    input  logic [1:0]          wr_kind,
    input  logic [CH_IDX_W-1:0] wr_chan,
    input  logic [7:0]          wr_data,
    output logic [LEVEL_W-1:0]  sample
);

    logic [NUM_CH-1:0]            wr_start, wr_end, wr_low, wr_ctrl;
    logic [NUM_CH-1:0][CNT_W-1:0] cnt_w, start_w;
    logic [NUM_CH-1:0]            flag_w, music_w, src_w;

    tone_wr_decode #(.N_CH(NUM_CH), .IDX_W(CH_IDX_W)) u_dec (
        .wr_en    (wr_en),
        .wr_kind  (wr_kind),
        .wr_chan  (wr_chan),
        .wr_start (wr_start),
        .wr_end   (wr_end),
        .wr_low   (wr_low),
        .wr_ctrl  (wr_ctrl)
    );

    genvar gi;
    generate
        for (gi = 0; gi < NUM_CH; gi++) begin : g_ch
            tone_channel #(.W(CNT_W)) u_ch (
                .clk      (clk),
                .rst_n    (rst_n),
                .osc_tick (osc_tick),
                .rd_pulse (rd_pulse[gi]),
                .wr_start (wr_start[gi]),
                .wr_end   (wr_end[gi]),
                .wr_low   (wr_low[gi]),
                .wr_ctrl  (wr_ctrl[gi]),
                .wr_data  (wr_data),
                .cnt_o    (cnt_w[gi]),
                .start_o  (start_w[gi]),
                .flag_o   (flag_w[gi]),
                .tone_o   (music_w[gi]),
                .src_o    (src_w[gi])
            );
        end
    endgenerate

    tone_mixer #(.N_CH(NUM_CH), .LW(LEVEL_W)) u_mix (
        .flag  (flag_w),
        .tone  (music_w),
        .level (sample)
    );

endmodule

// File: rtl/tone_music_gen_chk.sv
// Checker: temporal properties of the tone mixer, bound to the top module.
// Assumes the top exposes its channel state nets by the names used here.
module tone_music_gen_chk
    import tone_pkg::*;
(
    input logic                            clk,
    input logic                            rst_n,
    input logic                            osc_tick,
    input logic [NUM_CH-1:0]               rd_pulse,
    input logic                            wr_en,
    input logic [LEVEL_W-1:0]              sample,
    input logic [NUM_CH-1:0][CNT_W-1:0]    cnt_w,
    input logic [NUM_CH-1:0][CNT_W-1:0]    start_w,
    input logic [NUM_CH-1:0]               flag_w,
    input logic [NUM_CH-1:0]               music_w,
    input logic [NUM_CH-1:0]               src_w
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> sample == 4'h0);

    // R2
    no_tone_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (music_w == '0) |-> sample == 4'h0);

    // R3
    legal_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample inside {4'h0, 4'h4, 4'h5, 4'h9, 4'h6, 4'hA, 4'hB, 4'hF});

    genvar gi;
    generate
        for (gi = 0; gi < NUM_CH; gi++) begin : g_chk
            // R4
            idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (!osc_tick && !rd_pulse[gi] && !wr_en) |=> $stable(cnt_w[gi]));
            // R4
            reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (music_w[gi] && src_w[gi] && osc_tick && cnt_w[gi] == '0 && !wr_en)
                |=> cnt_w[gi] == $past(start_w[gi]));
            // R5
            start_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (cnt_w[gi] == start_w[gi]) |=> flag_w[gi]);
            // R9
            pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (!src_w[gi] && !rd_pulse[gi] && !wr_en) |=> $stable(cnt_w[gi]));
        end
    endgenerate

endmodule

bind tone_music_gen tone_music_gen_chk u_chk (.*);

// File: tb/tone_music_gen_test.sv
module tone_music_gen_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       osc_tick = 1'b0;
    logic [2:0] rd_pulse = 3'b000;
    logic       wr_en = 1'b0;
    logic [1:0] wr_kind = 2'd0;
    logic [1:0] wr_chan = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic [3:0] sample;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // Bench-side model
    int m_cnt[3], m_start[3], m_end[3];
    bit m_flag[3], m_tone[3], m_src[3];

    tone_music_gen uut (
        .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .rd_pulse(rd_pulse),
        .wr_en(wr_en), .wr_kind(wr_kind), .wr_chan(wr_chan),
        .wr_data(wr_data), .sample(sample)
    );

    always #5 clk = ~clk;

    function automatic int expect_level();
        int lv = 0;
        if (m_tone[0] && m_flag[0]) lv += 6;
        if (m_tone[1] && m_flag[1]) lv += 5;
        if (m_tone[2] && m_flag[2]) lv += 4;
        return lv;
    endfunction

    task automatic model_reset();
        for (int c = 0; c < 3; c++) begin
            m_cnt[c] = 0; m_start[c] = 0; m_end[c] = 0;
            m_flag[c] = 0; m_tone[c] = 0; m_src[c] = 0;
        end
    endtask

    task automatic settle_flags();
        for (int c = 0; c < 3; c++) begin
            if (m_cnt[c] == m_start[c]) m_flag[c] = 1;
            else if (m_cnt[c] == m_end[c]) m_flag[c] = 0;
        end
    endtask

    task automatic check(input string req, input int exp);
        n_chk++;
        if (int'(sample) != exp) begin
            n_bad++;
            $display("FAIL %s: sample=%0h expected=%0h", req, sample, exp);
        end
    endtask

    task automatic finish_op(input string req);
        @(negedge clk);
        wr_en = 0; osc_tick = 0; rd_pulse = 3'b000;
        @(negedge clk);
        settle_flags();
        check(req, expect_level());
    endtask

    task automatic wr(input int kind, input int ch, input int data, input string req);
        @(negedge clk);
        wr_en = 1; wr_kind = 2'(kind); wr_chan = 2'(ch); wr_data = 8'(data);
        if (ch < 3) begin
            case (kind)
                0: m_start[ch] = data;
                1: m_end[ch] = data;
                2: m_cnt[ch] = m_tone[ch] ? m_start[ch] : data;
                default: begin
                    m_tone[ch] = data[4];
                    m_src[ch] = data[5];
                end
            endcase
        end
        finish_op(req);
    endtask

    task automatic step_model(input int c);
        if (m_cnt[c] == 0) m_cnt[c] = m_start[c];
        else m_cnt[c] = m_cnt[c] - 1;
    endtask

    task automatic tick(input string req);
        @(negedge clk);
        osc_tick = 1;
        for (int c = 0; c < 3; c++)
            if (m_tone[c] && m_src[c]) step_model(c);
        finish_op(req);
    endtask

    task automatic pulse(input int ch, input string req);
        @(negedge clk);
        rd_pulse[ch] = 1'b1;
        if (m_tone[ch] && !m_src[ch]) step_model(ch);
        finish_op(req);
    endtask

    initial begin
        #1_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: run did not end, actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        settle_flags();
        check("R1 reset", 0);

        // R3 / R2: flags held high (start 0, end 128), walk tone-mode combos
        for (int c = 0; c < 3; c++) wr(1, c, 8'h80, "R3 setup");
        for (int combo = 0; combo < 8; combo++) begin
            wr(3, 0, combo[2] ? 8'h30 : 8'h20, "R2 ch0 mode");
            wr(3, 1, combo[1] ? 8'h30 : 8'h20, "R2 ch1 mode");
            wr(3, 2, combo[0] ? 8'h30 : 8'h20, "R3 mixer index");
            repeat (4) @(negedge clk);
            check("R3 mixer hold", expect_level());
        end
        // R10: upper pointer bits in control byte have no effect
        wr(3, 0, 8'h3F, "R10 ctrl upper bits");
        wr(3, 1, 8'h00, "R2 ch1 off");
        wr(3, 2, 8'h00, "R2 ch2 off");

        // R4 / R5 / R6: sweep start 0..7 against end 0..8 on channel 0
        for (int s = 0; s < 8; s++) begin
            for (int e = 0; e < 9; e++) begin
                wr(0, 0, s, "R4 start");
                wr(1, 0, e, "R5 end");
                wr(2, 0, 0, "R8 load in tone mode");
                for (int t = 0; t < 2 * (s + 1) + 1; t++)
                    tick((s == e) ? "R6 equal counts" : "R5 duty sweep");
            end
        end

        // R7: start change mid-period takes effect at next reload
        wr(3, 2, 8'h30, "R7 ch2 tone");
        wr(0, 2, 4, "R7 start");
        wr(1, 2, 2, "R7 end");
        wr(2, 2, 0, "R7 load");
        tick("R7 first step");
        wr(0, 2, 6, "R7 start rewrite");
        for (int t = 0; t < 12; t++) tick("R7 after rewrite");

        // R8: pointer-low outside tone mode loads the byte
        wr(3, 0, 8'h20, "R8 ch0 off");
        wr(0, 0, 9, "R8 start");
        wr(1, 0, 3, "R8 end");
        wr(2, 0, 3, "R8 load raw");
        wr(2, 0, 9, "R8 load raw");
        wr(3, 0, 8'h30, "R8 tone on");
        tick("R8 step");

        // R9: read-pulse source on channel 1 ignores oscillator ticks
        wr(3, 2, 8'h00, "R9 ch2 off");
        wr(3, 0, 8'h00, "R9 ch0 off");
        wr(0, 1, 3, "R9 start");
        wr(1, 1, 1, "R9 end");
        wr(3, 1, 8'h10, "R9 pulse source");
        wr(2, 1, 0, "R9 load");
        tick("R9 tick ignored");
        tick("R9 tick ignored");
        pulse(1, "R9 pulse step");
        pulse(1, "R9 pulse step");
        pulse(0, "R9 other pulse ignored");
        for (int t = 0; t < 6; t++) pulse(1, "R9 pulse period");

        // R10: channel index 3 writes nothing
        wr(0, 3, 200, "R10 chan3 start");
        wr(2, 3, 5, "R10 chan3 low");
        for (int t = 0; t < 5; t++) pulse(1, "R10 state kept");

        // R1: reset mid-run
        @(negedge clk);
        rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        model_reset();
        @(negedge clk);
        check("R1 reset again", 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule